// File: doc/BRIEF.md
# Three-Stage I/Q Decimating FIR Chain

This block takes a complex baseband stream, one I sample and one Q sample per valid cycle, and lowers its rate fiftyfold. A 60 MHz input stream leaves as a 1.2 MHz output stream. Three low-pass decimating FIR stages sit in a row and reduce the rate by 5, then by 5, then by 2. Each stage works in polyphase fashion. It shifts every accepted sample into a short delay line, but it computes a dot product only on the accepted sample that completes its ratio. The discarded output phases therefore cost no arithmetic.

The I and Q rails use the same phase counter, valid strobe and coefficient set inside each stage, so the two rails stay aligned. Each stage rounds its result and saturates it to the data width before passing it to the next stage. The input valid may drop at any time; an idle cycle changes no state. The output valid is a one-cycle pulse that marks a new I/Q pair.

Top module: `decim_chain`

## Requirements
- R1: The block emits exactly one output pair, as a single-cycle `out_vld` pulse, for every 50 accepted input pairs.
- R2: The stages decimate by 5, then 5, then 2. Reset clears every phase counter, so the first output after reset follows exactly the 50th accepted input after reset.
- R3: `out_vld` rises on the second rising edge after the edge that accepts the input completing a group of 50.
- R4: A cycle with `in_vld` low changes no delay line, phase counter or output, so gaps in the input do not alter the output values.
- R5: Each stage computes y = sat(floor((sum over k of c[k]*x[n-k] + 128) / 256)), where x[n] is the newest accepted sample. Coefficient c[k] is 12*min(k+1, T-k), and T is 10, 10 and 8 taps for the three stages.
- R6: A stage result beyond the signed 16-bit range is clamped to 32767 or -32768.
- R7: I and Q use identical coefficients and timing: equal inputs on both rails give equal outputs, and one `out_vld` qualifies both rails.
- R8: While `rst` is high, `out_vld`, `out_i` and `out_q` are 0 and all delay lines are cleared.
- R9: Once a constant input has settled, the outputs are 1853 for 1000, -1853 for -1000, 0 for 0, 30719 for 32767 and -30720 for -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input pair valid |
| in_i | input | 16 | In-phase input sample, two's complement |
| in_q | input | 16 | Quadrature input sample, two's complement |
| out_vld | output | 1 | Output pair valid, one-cycle pulse |
| out_i | output | 16 | In-phase decimated output |
| out_q | output | 16 | Quadrature decimated output |

## Verification
A phase counter that is off by one shifts the output strobe by a few input samples. This shows up at the very first output after reset, because that output no longer comes after exactly 50 inputs. A stale or misshifted delay-line entry, or a wrong coefficient, disturbs only the outputs whose window contains that entry. For this reason every output in a long run with gaps is compared against a bit-exact reference, and each output is checked within one output period. A saturation or rounding fault shows only at the extremes, so settled full-scale constant inputs are driven on both rails with opposite signs.

// File: rtl/decim_pkg.sv
package decim_pkg;
  localparam int NSTAGE = 3;

  // Symmetric triangular tap weight for position k of a taps-long filter.
  function automatic int tri_coef(int taps, int k, int scale);
    int w;
    w = (k + 1 < taps - k) ? k + 1 : taps - k;
    return w * scale;
  endfunction

  // Add half an LSB, then shift right arithmetically (floor).
  function automatic longint round_half_up(longint acc, int frac);
    return (acc + (longint'(1) <<< (frac - 1))) >>> frac;
  endfunction

  // Clamp to the signed range of a dw-bit word.
  function automatic longint clamp_signed(longint v, int dw);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (dw - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/decim_phase_ctrl.sv
module decim_phase_ctrl #(
  parameter int RATIO = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic in_vld,
  output logic fire
);
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (in_vld) phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  assign fire = in_vld && (phase == LAST);

  p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);
  p_phase_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(phase));
endmodule

// File: rtl/decim_mac.sv
module decim_mac
  import decim_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 8,
  parameter int TAPS  = 10,
  parameter int SCALE = 12,
  parameter int FRAC  = 8
) (
  input  logic signed [DW-1:0] win [TAPS],
  output logic signed [DW-1:0] y,
  output logic                 sat_hit
);
  localparam int ACC_W = DW + CW + $clog2(TAPS) + 1;

  logic signed [CW-1:0]    coef [TAPS];
  logic signed [ACC_W-1:0] acc;
  longint                  rnd;
  longint                  clp;

  // Constant coefficient ROM, one entry per tap.
  for (genvar k = 0; k < TAPS; k++) begin : g_rom
    assign coef[k] = CW'(tri_coef(TAPS, k, SCALE));
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++)
      acc += ACC_W'(win[k]) * ACC_W'(coef[k]);
    rnd     = round_half_up(longint'(acc), FRAC);
    clp     = clamp_signed(rnd, DW);
    y       = DW'(clp);
    sat_hit = (rnd != clp);
  end
endmodule

// File: rtl/decim_stage.sv
module decim_stage #(
  parameter int DW    = 16,
  parameter int CW    = 8,
  parameter int RATIO = 5,
  parameter int TAPS  = 10,
  parameter int SCALE = 12,
  parameter int FRAC  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic                 fire;
  logic signed [DW-1:0] line_i [TAPS-1];
  logic signed [DW-1:0] line_q [TAPS-1];
  logic signed [DW-1:0] win_i  [TAPS];
  logic signed [DW-1:0] win_q  [TAPS];
  logic signed [DW-1:0] y_i;
  logic signed [DW-1:0] y_q;
  logic                 sat_i;
  logic                 sat_q;

  decim_phase_ctrl #(.RATIO(RATIO)) u_ctrl (
    .clk(clk), .rst(rst), .in_vld(in_vld), .fire(fire)
  );

  // Window: newest sample straight from the input, older ones from the line.
  assign win_i[0] = in_i;
  assign win_q[0] = in_q;
  for (genvar k = 1; k < TAPS; k++) begin : g_win
    assign win_i[k] = line_i[k-1];
    assign win_q[k] = line_q[k-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS - 1; k++) begin
        line_i[k] <= '0;
        line_q[k] <= '0;
      end
    end else if (in_vld) begin
      line_i[0] <= in_i;
      line_q[0] <= in_q;
      for (int k = 1; k < TAPS - 1; k++) begin
        line_i[k] <= line_i[k-1];
        line_q[k] <= line_q[k-1];
      end
    end
  end

  decim_mac #(.DW(DW), .CW(CW), .TAPS(TAPS), .SCALE(SCALE), .FRAC(FRAC)) u_mac_i (
    .win(win_i), .y(y_i), .sat_hit(sat_i)
  );
  decim_mac #(.DW(DW), .CW(CW), .TAPS(TAPS), .SCALE(SCALE), .FRAC(FRAC)) u_mac_q (
    .win(win_q), .y(y_q), .sat_hit(sat_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_i   <= '0;
      out_q   <= '0;
    end else begin
      out_vld <= fire;
      if (fire) begin
        out_i <= y_i;
        out_q <= y_q;
      end
    end
  end

  p_sat_clamp_i_r6: assert property (@(posedge clk) disable iff (rst)
    (fire && sat_i) |=> (out_i == MAXV || out_i == MINV));
  p_sat_clamp_q_r6: assert property (@(posedge clk) disable iff (rst)
    (fire && sat_q) |=> (out_q == MAXV || out_q == MINV));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(line_i[0]) && $stable(line_q[0]) && $stable(out_i) && $stable(out_q)));
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);
endmodule

// File: rtl/decim_chain.sv
module decim_chain
  import decim_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 8,
  parameter int SCALE = 12,
  parameter int FRAC  = 8,
  parameter int RATIO [NSTAGE] = '{5, 5, 2},
  parameter int TAPS  [NSTAGE] = '{10, 10, 8}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  function automatic int total_ratio();
    int p;
    p = 1;
    for (int s = 0; s < NSTAGE; s++) p *= RATIO[s];
    return p;
  endfunction

  localparam int TOTAL = total_ratio();
  localparam int SW    = $clog2(TOTAL + 1);

  logic                 vld_c [NSTAGE+1];
  logic signed [DW-1:0] i_c   [NSTAGE+1];
  logic signed [DW-1:0] q_c   [NSTAGE+1];

  assign vld_c[0] = in_vld;
  assign i_c[0]   = in_i;
  assign q_c[0]   = in_q;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    decim_stage #(
      .DW(DW), .CW(CW), .RATIO(RATIO[s]), .TAPS(TAPS[s]), .SCALE(SCALE), .FRAC(FRAC)
    ) u_stage (
      .clk(clk), .rst(rst),
      .in_vld(vld_c[s]), .in_i(i_c[s]), .in_q(q_c[s]),
      .out_vld(vld_c[s+1]), .out_i(i_c[s+1]), .out_q(q_c[s+1])
    );
  end

  assign out_vld = vld_c[NSTAGE];
  assign out_i   = i_c[NSTAGE];
  assign out_q   = q_c[NSTAGE];

  // Checker state: accepted inputs since reset, saturating at TOTAL.
  logic [SW-1:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (in_vld && seen != SW'(TOTAL)) seen <= seen + 1'b1;
  end

  p_first_out_r2: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (seen == SW'(TOTAL)));
  p_chain_step_r3: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(vld_c[NSTAGE-1]));
  p_out_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);
endmodule

// File: tb/tb_decim_chain.sv
module tb_decim_chain;
  localparam int CLK_P = 10;
  localparam int QN    = 256;
  localparam int B_RATIO [3] = '{5, 5, 2};
  localparam int B_TAPS  [3] = '{10, 10, 8};
  // in_i, in_q, settled out_i, settled out_q  (R9, R6, R7)
  localparam int DC_TAB [5][4] = '{
    '{1000, -1000, 1853, -1853},
    '{0, 1000, 0, 1853},
    '{32767, -32768, 30719, -30720},
    '{-32768, 32767, -30720, 30719},
    '{-1000, 0, -1853, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic signed [15:0] in_i = '0;
  logic signed [15:0] in_q = '0;
  logic out_vld;
  logic signed [15:0] out_i;
  logic signed [15:0] out_q;

  int checks = 0;
  int errors = 0;

  longint act_i [QN];
  longint act_q [QN];
  longint exp_i [QN];
  longint exp_q [QN];
  int act_n = 0;
  int exp_n = 0;

  longint mh [3][2][10];
  int     mp [3];

  always #(CLK_P/2) clk = ~clk;

  decim_chain dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
  );

  always @(negedge clk) begin
    if (!rst && out_vld && act_n < QN) begin
      act_i[act_n] = longint'(out_i);
      act_q[act_n] = longint'(out_q);
      act_n = act_n + 1;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Reference: floor division written with integer divide and correction.
  function automatic longint ref_stage(int s, int r);
    longint acc, num, q, c;
    acc = 0;
    for (int k = 0; k < B_TAPS[s]; k++) begin
      c = (k < B_TAPS[s] / 2) ? (k + 1) * 12 : (B_TAPS[s] - k) * 12;
      acc += mh[s][r][k] * c;
    end
    num = acc + 128;
    q = num / 256;
    if (num < 0 && q * 256 != num) q = q - 1;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic model_clear();
    for (int s = 0; s < 3; s++) begin
      mp[s] = 0;
      for (int r = 0; r < 2; r++)
        for (int k = 0; k < 10; k++) mh[s][r][k] = 0;
    end
  endtask

  task automatic model_push(longint xi, longint xq);
    longint vi, vq;
    vi = xi;
    vq = xq;
    for (int s = 0; s < 3; s++) begin
      for (int k = 9; k > 0; k--) begin
        mh[s][0][k] = mh[s][0][k-1];
        mh[s][1][k] = mh[s][1][k-1];
      end
      mh[s][0][0] = vi;
      mh[s][1][0] = vq;
      mp[s] = mp[s] + 1;
      if (mp[s] < B_RATIO[s]) return;
      mp[s] = 0;
      vi = ref_stage(s, 0);
      vq = ref_stage(s, 1);
    end
    if (exp_n < QN) begin
      exp_i[exp_n] = vi;
      exp_q[exp_n] = vq;
      exp_n = exp_n + 1;
    end
  endtask

  task automatic drive(bit v, longint xi, longint xq);
    @(negedge clk);
    in_vld = v;
    in_i = 16'(xi);
    in_q = 16'(xq);
    if (v) model_push(xi, xq);
  endtask

  task automatic flush(int n);
    for (int c = 0; c < n; c++) drive(1'b0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_vld = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_vld == 1'b0, "R8 out_vld in reset", longint'(out_vld), 0);
    chk(out_i == 0 && out_q == 0, "R8 outputs in reset", longint'(out_i), 0);
    model_clear();
    act_n = 0;
    exp_n = 0;
    rst = 1'b0;
  endtask

  task automatic compare_all(string req);
    chk(act_n == exp_n, {req, " output count"}, act_n, exp_n);
    for (int j = 0; j < act_n && j < exp_n; j++) begin
      chk(act_i[j] == exp_i[j], {req, " I sample"}, act_i[j], exp_i[j]);
      chk(act_q[j] == exp_q[j], {req, " Q sample"}, act_q[j], exp_q[j]);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    int nv;
    model_clear();
    repeat (3) @(negedge clk);
    do_reset();

    // R2 and R3: first output after exactly 50 inputs, two edges later.
    for (int n = 0; n < 49; n++) drive(1'b1, 1000, -500);
    chk(act_n == 0, "R2 no output before 50th input", act_n, 0);
    drive(1'b1, 1000, -500);
    for (int c = 1; c <= 4; c++) begin
      drive(1'b0, 0, 0);
      chk(out_vld == (c == 3), "R3 output latency", longint'(out_vld), longint'(c == 3));
    end
    compare_all("R5 ramp-in");

    // R2, R8: reset mid-stream restarts phase counting.
    for (int n = 0; n < 23; n++) drive(1'b1, 7000, 7000);
    do_reset();
    for (int n = 0; n < 49; n++) drive(1'b1, 3000, -3000);
    flush(5);
    chk(act_n == 0, "R2 no output after 49 post-reset inputs", act_n, 0);
    drive(1'b1, 3000, -3000);
    flush(5);
    chk(act_n == 1, "R2 one output after 50 post-reset inputs", act_n, 1);
    compare_all("R8 cleared history");

    // R9, R6, R7: settled constant inputs from the table.
    for (int e = 0; e < 5; e++) begin
      do_reset();
      for (int n = 0; n < 600; n++) drive(1'b1, DC_TAB[e][0], DC_TAB[e][1]);
      flush(5);
      chk(act_n == 12, "R1 twelve outputs per 600 inputs", act_n, 12);
      if (act_n > 0) begin
        chk(act_i[act_n-1] == DC_TAB[e][2], "R9 settled I (R6 at full scale)",
            act_i[act_n-1], DC_TAB[e][2]);
        chk(act_q[act_n-1] == DC_TAB[e][3], "R9 settled Q (R6 at full scale)",
            act_q[act_n-1], DC_TAB[e][3]);
      end
      compare_all("R5 constant input");
    end

    // R4, R1, R5: pseudo-random data with gaps in the valid strobe.
    do_reset();
    lf = 16'hACE1;
    nv = 0;
    for (int n = 0; n < 1500; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[0] | lf[3]) begin
        drive(1'b1, longint'($signed(lf)), longint'($signed(~lf)));
        nv++;
      end else begin
        drive(1'b0, 0, 0);
      end
    end
    flush(5);
    chk(act_n == nv / 50, "R1 outputs per 50 accepted inputs", act_n, nv / 50);
    compare_all("R4 gapped random stream");

    // R7, R5: impulse on both rails gives identical rails.
    do_reset();
    drive(1'b1, 20000, 20000);
    for (int n = 0; n < 399; n++) drive(1'b1, 0, 0);
    flush(5);
    for (int j = 0; j < act_n; j++)
      chk(act_i[j] == act_q[j], "R7 I equals Q for equal inputs", act_i[j], act_q[j]);
    compare_all("R5 impulse response");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule